// File: doc/BRIEF.md
# Single-Wire Session and Flag Controller

This block sits above the token decoder of a single-wire, half-duplex slave. The decoder hands it wake events and received data bits. The block gathers bits into 8-bit flags, arriving least significant bit first, and acts on three flag values:

- a command flag opens a window in which bits are passed on to the command block receiver;
- a transmit flag starts a turnaround delay, after which a one-cycle request is sent to the bit serializer;
- a sleep flag puts the block to sleep.

Every other flag value is dropped without a trace.

Two independent counters can force sleep at any time. An inactivity timer limits the gap between tokens. A watchdog limits the total time awake since the last wake. While the command engine executes, and during a pause window, the bus is ignored completely. Each time the block enters sleep, it pulses a clear to the command engine and its buffers. All time constants are parameters counted in clock cycles.

Top module: `sw_session_ctrl`

## Requirements
- R1: After reset the block is asleep (`awake_o`=0). While asleep, received bits are discarded: nothing is forwarded, no flag is formed and no transmit request is raised. Only `wake_i` makes the block awake, on the next clock edge.
- R2: Flag bits are assembled least significant bit first. A completed flag of 0x66 switches to block reception, where every received bit appears on `rx_fwd_valid_o`/`rx_fwd_bit_o` in the same cycle. Bit order matters: 0x33, which is 0xCC with its bit order reversed, does not put the block to sleep.
- R3: A completed flag of 0x99 raises `tx_req_o` for exactly one cycle, TURN_CYC cycles after the edge that took the last flag bit. The first request after a wake reports `tx_src_o`=0 (wake status, byte 0x11).
- R4: A completed flag of 0xCC puts the block to sleep on that same edge. `engine_clr_o` is then high for the first sleeping cycle. Every other entry into sleep also raises `engine_clr_o`.
- R5: Any other completed flag value changes nothing: no request, no state change. The next eight bits form a fresh flag.
- R6: In flag reception and block reception, the block goes to sleep TOUT_CYC cycles after the last accepted bit. This timer is also running right after a wake, before any bit has arrived.
- R7: The inactivity timer does not run while busy, paused, in turnaround or while transmitting.
- R8: The block goes to sleep WDOG_CYC cycles after the wake edge, whatever the bus activity. A `wake_i` pulse while awake does not restart this count.
- R9: `blk_done_i` with `blk_pause_i`=0 during block reception makes the block busy (`busy_o`). While busy, all bits are ignored, including transmit flags. `exec_done_i` ends the busy state and makes the pending response `tx_src_o`=1 (engine response).
- R10: `blk_done_i` with `blk_pause_i`=1 starts a pause of PAUSE_CYC cycles (`paused_o`) during which all bits are ignored. After the pause the pending response is `tx_src_o`=2 (pause acknowledge, byte 0x00).
- R11: The pending response does not change when it is sent. A repeated 0x99 reports the same `tx_src_o`. `tx_done_i` returns the block to flag reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Decoded wake event |
| rx_valid_i | input | 1 | Received data bit is valid this cycle |
| rx_bit_i | input | 1 | Received data bit value |
| blk_done_i | input | 1 | Command block receiver has finished a block |
| blk_pause_i | input | 1 | Qualifies `blk_done_i`: the block was a pause command |
| exec_done_i | input | 1 | Command execution has finished and a response is ready |
| tx_done_i | input | 1 | Serializer has finished sending the response |
| rx_fwd_valid_o | output | 1 | Forwarded bit is valid (block reception only) |
| rx_fwd_bit_o | output | 1 | Forwarded bit value |
| tx_req_o | output | 1 | One-cycle transmit request to the serializer |
| tx_src_o | output | 2 | Response to send: 0 wake status, 1 engine response, 2 pause acknowledge |
| awake_o | output | 1 | Block is awake |
| busy_o | output | 1 | Command execution in progress |
| paused_o | output | 1 | Pause window in progress |
| engine_clr_o | output | 1 | Clear for the command engine and buffers, first cycle of sleep |

## Verification
The bench targets the exact edge on which each timer fires:

- A timer one cycle late or early shows up as `awake_o` or `tx_req_o` differing from the reference in one cycle.
- A watchdog that restarts on a stray wake keeps the block awake past WDOG_CYC.

It sends the bit-reversed image of the sleep flag. A design that assembles flags most significant bit first would fall asleep on it.

It also sends transmit flags while busy and while paused, and leaves the bus silent for twice TOUT_CYC while busy. A design that listens during those windows would raise a stray request. A design whose inactivity timer keeps counting would fall asleep in the middle of execution.

// File: rtl/sw_sess_pkg.sv
package sw_sess_pkg;
  localparam int unsigned FLAG_W = 8;

  typedef enum logic [2:0] {
    ST_SLEEP, ST_FLAG, ST_BLOCK, ST_BUSY, ST_PAUSE, ST_TURN, ST_TX
  } sess_state_e;

  typedef enum logic [1:0] {
    RSP_WAKE   = 2'd0,
    RSP_ENGINE = 2'd1,
    RSP_PAUSE  = 2'd2
  } rsp_src_e;

  localparam logic [FLAG_W-1:0] FLAG_CMD   = 8'h66;
  localparam logic [FLAG_W-1:0] FLAG_XMIT  = 8'h99;
  localparam logic [FLAG_W-1:0] FLAG_SLEEP = 8'hCC;
endpackage

// File: rtl/sw_flag_shift.sv
module sw_flag_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         bit_valid_i,
  input  logic         bit_i,
  output logic         byte_valid_o,
  output logic [W-1:0] byte_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sr_q;

  // LSB arrives first and ends up at bit 0
  assign byte_o       = {bit_i, sr_q};
  assign byte_valid_o = bit_valid_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      sr_q  <= {bit_i, sr_q[W-2:1]};
    end
  end
endmodule

// File: rtl/sw_cycle_timer.sv
module sw_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sw_session_ctrl.sv
module sw_session_ctrl
  import sw_sess_pkg::*;
#(
  parameter int unsigned TOUT_CYC  = 16_250_000,
  parameter int unsigned WDOG_CYC  = 1_000_000_000,
  parameter int unsigned TURN_CYC  = 15_000,
  parameter int unsigned PAUSE_CYC = 6_250_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wake_i,
  input  logic       rx_valid_i,
  input  logic       rx_bit_i,
  input  logic       blk_done_i,
  input  logic       blk_pause_i,
  input  logic       exec_done_i,
  input  logic       tx_done_i,
  output logic       rx_fwd_valid_o,
  output logic       rx_fwd_bit_o,
  output logic       tx_req_o,
  output logic [1:0] tx_src_o,
  output logic       awake_o,
  output logic       busy_o,
  output logic       paused_o,
  output logic       engine_clr_o
);
  sess_state_e state_q, state_d;
  rsp_src_e    rsp_q, rsp_d;
  logic        clr_q;
  logic        kill;
  logic        awake, listening, tok;
  logic        flag_vld;
  logic [FLAG_W-1:0] flag_byte;
  logic        wdog_exp, idle_exp, turn_exp, pause_exp;

  assign awake     = (state_q != ST_SLEEP);
  assign listening = (state_q == ST_FLAG) || (state_q == ST_BLOCK);
  assign tok       = rx_valid_i && listening;

  sw_flag_shift #(.W(FLAG_W)) u_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (state_q != ST_FLAG),
    .bit_valid_i  (rx_valid_i && (state_q == ST_FLAG)),
    .bit_i        (rx_bit_i),
    .byte_valid_o (flag_vld),
    .byte_o       (flag_byte)
  );

  sw_cycle_timer #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (awake),
    .restart_i (1'b0),
    .expire_o  (wdog_exp)
  );

  sw_cycle_timer #(.LIMIT(TOUT_CYC)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (listening),
    .restart_i (tok),
    .expire_o  (idle_exp)
  );

  sw_cycle_timer #(.LIMIT(TURN_CYC)) u_turn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_TURN),
    .restart_i (1'b0),
    .expire_o  (turn_exp)
  );

  sw_cycle_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_PAUSE),
    .restart_i (1'b0),
    .expire_o  (pause_exp)
  );

  always_comb begin
    state_d = state_q;
    rsp_d   = rsp_q;
    kill    = 1'b0;
    case (state_q)
      ST_SLEEP: if (wake_i) begin
        state_d = ST_FLAG;
        rsp_d   = RSP_WAKE;
      end
      ST_FLAG: if (flag_vld) begin
        case (flag_byte)
          FLAG_CMD:   state_d = ST_BLOCK;
          FLAG_XMIT:  state_d = ST_TURN;
          FLAG_SLEEP: kill    = 1'b1;
          default:    ;
        endcase
      end
      ST_BLOCK: if (blk_done_i) state_d = blk_pause_i ? ST_PAUSE : ST_BUSY;
      ST_BUSY: if (exec_done_i) begin
        state_d = ST_FLAG;
        rsp_d   = RSP_ENGINE;
      end
      ST_PAUSE: if (pause_exp) begin
        state_d = ST_FLAG;
        rsp_d   = RSP_PAUSE;
      end
      ST_TURN: if (turn_exp) state_d = ST_TX;
      ST_TX:   if (tx_done_i) state_d = ST_FLAG;
      default: state_d = ST_SLEEP;
    endcase
    // either timer overrides whatever the state machine chose
    if (awake && (wdog_exp || idle_exp)) kill = 1'b1;
    if (kill) state_d = ST_SLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      rsp_q   <= RSP_WAKE;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
      clr_q   <= kill;
    end
  end

  assign rx_fwd_valid_o = rx_valid_i && (state_q == ST_BLOCK);
  assign rx_fwd_bit_o   = rx_bit_i;
  assign tx_req_o       = turn_exp;
  assign tx_src_o       = rsp_q;
  assign awake_o        = awake;
  assign busy_o         = (state_q == ST_BUSY);
  assign paused_o       = (state_q == ST_PAUSE);
  assign engine_clr_o   = clr_q;
endmodule

// File: rtl/sw_session_chk.sv
module sw_session_chk #(
  parameter int unsigned WDOG_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wake_i,
  input logic awake_o,
  input logic busy_o,
  input logic paused_o,
  input logic tx_req_o,
  input logic rx_fwd_valid_o,
  input logic engine_clr_o
);
  logic [31:0] awake_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      awake_cnt_q <= '0;
    else if (!awake_o) awake_cnt_q <= '0;
    else               awake_cnt_q <= awake_cnt_q + 1'b1;
  end

  assert_sleep_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o |-> (!tx_req_o && !rx_fwd_valid_o));

  assert_wake_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awake_o) |-> $past(wake_i));

  assert_txreq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);

  assert_clr_asleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_clr_o |-> !awake_o);

  assert_wdog_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |-> (awake_cnt_q < WDOG_CYC));

  assert_busy_deaf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!rx_fwd_valid_o && !tx_req_o));

  assert_pause_deaf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!rx_fwd_valid_o && !tx_req_o && !busy_o));
endmodule

bind sw_session_ctrl sw_session_chk #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wake_i         (wake_i),
  .awake_o        (awake_o),
  .busy_o         (busy_o),
  .paused_o       (paused_o),
  .tx_req_o       (tx_req_o),
  .rx_fwd_valid_o (rx_fwd_valid_o),
  .engine_clr_o   (engine_clr_o)
);

// File: tb/tb_sw_session_ctrl.sv
module tb_sw_session_ctrl;
  localparam int unsigned TOUT  = 40;
  localparam int unsigned WDOG  = 3000;
  localparam int unsigned TURN  = 6;
  localparam int unsigned PAUSE = 20;

  localparam int M_SLEEP = 0, M_FLAG = 1, M_BLK = 2, M_BUSY = 3,
                 M_PAUSE = 4, M_TURN = 5, M_TX = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake = 0, rx_valid = 0, rx_bit = 0, blk_done = 0, blk_pause = 0;
  logic exec_done = 0, tx_done = 0;
  logic rx_fwd_valid, rx_fwd_bit, tx_req, awake, busy, paused, engine_clr;
  logic [1:0] tx_src;

  sw_session_ctrl #(.TOUT_CYC(TOUT), .WDOG_CYC(WDOG), .TURN_CYC(TURN), .PAUSE_CYC(PAUSE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .rx_valid_i(rx_valid), .rx_bit_i(rx_bit),
    .blk_done_i(blk_done), .blk_pause_i(blk_pause), .exec_done_i(exec_done),
    .tx_done_i(tx_done), .rx_fwd_valid_o(rx_fwd_valid), .rx_fwd_bit_o(rx_fwd_bit),
    .tx_req_o(tx_req), .tx_src_o(tx_src), .awake_o(awake), .busy_o(busy),
    .paused_o(paused), .engine_clr_o(engine_clr)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_mode = M_SLEEP, m_flag = 0, m_nbits = 0, m_pc = 0;
  int m_sw = 0, m_st = 0, m_rsp = 0, m_clr = 0;

  task automatic model_step();
    int kill = 0;
    bit lis, tk;
    int nst;
    m_clr = 0;
    if (m_mode == M_SLEEP) begin
      if (wake) begin
        m_mode = M_FLAG; m_rsp = 0; m_sw = 0; m_st = 0; m_nbits = 0;
      end
      return;
    end
    lis = (m_mode == M_FLAG) || (m_mode == M_BLK);
    tk  = rx_valid && lis;
    if (m_sw == int'(WDOG) - 1) kill = 1;
    if (lis && !tk && m_st == int'(TOUT) - 1) kill = 1;
    nst = (lis && !tk) ? m_st + 1 : 0;
    case (m_mode)
      M_FLAG: if (rx_valid) begin
        m_flag = (m_flag >> 1) | (int'(rx_bit) << 7);
        m_nbits++;
        if (m_nbits == 8) begin
          m_nbits = 0;
          if (m_flag == 8'h66) m_mode = M_BLK;
          else if (m_flag == 8'h99) begin m_mode = M_TURN; m_pc = 0; end
          else if (m_flag == 8'hCC) kill = 1;
        end
      end
      M_BLK: if (blk_done) begin
        if (blk_pause) begin m_mode = M_PAUSE; m_pc = 0; end
        else m_mode = M_BUSY;
      end
      M_BUSY: if (exec_done) begin m_mode = M_FLAG; m_rsp = 1; m_nbits = 0; end
      M_PAUSE: if (m_pc == int'(PAUSE) - 1) begin m_mode = M_FLAG; m_rsp = 2; m_nbits = 0; end
               else m_pc++;
      M_TURN: if (m_pc == int'(TURN) - 1) m_mode = M_TX; else m_pc++;
      M_TX: if (tx_done) begin m_mode = M_FLAG; m_nbits = 0; end
      default: ;
    endcase
    m_st = nst;
    m_sw++;
    if (kill) begin m_mode = M_SLEEP; m_clr = 1; m_sw = 0; m_st = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_SLEEP; m_rsp = 0; m_clr = 0; m_sw = 0; m_st = 0; m_nbits = 0;
    end else model_step();
  end

  // per-cycle comparison, away from the edge
  int awake_run = 0, last_run = 0, pause_run = 0, last_pause = 0;
  int txreq_n = 0, fwd_n = 0, clr_n = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit e_tx;
      e_tx = (m_mode == M_TURN) && (m_pc == int'(TURN) - 1);
      check(awake === (m_mode != M_SLEEP), "R1/R4/R6/R8", "awake_o", int'(awake), int'(m_mode != M_SLEEP));
      check(busy === (m_mode == M_BUSY), "R9", "busy_o", int'(busy), int'(m_mode == M_BUSY));
      check(paused === (m_mode == M_PAUSE), "R10", "paused_o", int'(paused), int'(m_mode == M_PAUSE));
      check(tx_req === e_tx, "R3", "tx_req_o", int'(tx_req), int'(e_tx));
      if (e_tx) check(int'(tx_src) == m_rsp, "R11", "tx_src_o", int'(tx_src), m_rsp);
      check(rx_fwd_valid === (rx_valid && m_mode == M_BLK), "R2", "rx_fwd_valid_o",
            int'(rx_fwd_valid), int'(rx_valid && m_mode == M_BLK));
      check(engine_clr === (m_clr != 0), "R4", "engine_clr_o", int'(engine_clr), m_clr);
      if (awake) awake_run++; else begin if (awake_run != 0) last_run = awake_run; awake_run = 0; end
      if (paused) pause_run++; else begin if (pause_run != 0) last_pause = pause_run; pause_run = 0; end
      if (tx_req) txreq_n++;
      if (rx_fwd_valid) fwd_n++;
      if (engine_clr) clr_n++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    rx_valid = 1; rx_bit = b;
    tick();
    rx_valid = 0;
    tick(2);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_wake();
    wake = 1; tick(); wake = 0; tick();
  endtask

  task automatic expect_tx(int src, string req);
    int got = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_req) begin got = 1; break; end
    end
    check(got == 1, req, "transmit request seen", got, 1);
    check(int'(tx_src) == src, req, "tx_src_o", int'(tx_src), src);
    tick(2);
    tx_done = 1; tick(); tx_done = 0; tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    tick(3);
    check(awake == 0 && tx_req == 0 && engine_clr == 0, "R1", "reset outputs", int'(awake), 0);
    rst_n = 1; tick(2);

    // R1: bits while asleep are dropped
    t0 = txreq_n;
    send_byte(8'h99); tick(TURN + 4);
    check(txreq_n == t0, "R1", "requests while asleep", txreq_n - t0, 0);
    check(awake == 0, "R1", "still asleep", int'(awake), 0);

    // R3: wake status first
    do_wake();
    check(awake == 1, "R1", "awake after wake", int'(awake), 1);
    send_byte(8'h99);
    expect_tx(0, "R3");
    // R11: re-read gives the same source
    send_byte(8'h99);
    expect_tx(0, "R11");

    // R5 and R2: ignored values, including bit-reversed sleep flag
    t0 = txreq_n;
    send_byte(8'h5A); send_byte(8'h33); tick(5);
    check(txreq_n == t0, "R5", "requests after ignored flag", txreq_n - t0, 0);
    check(awake == 1, "R2", "0x33 does not sleep", int'(awake), 1);
    send_byte(8'h99);
    expect_tx(0, "R5");

    // R2 / R9 / R7: command block, busy
    t0 = fwd_n;
    send_byte(8'h66);
    send_byte(8'hA5);
    check(fwd_n - t0 == 8, "R2", "forwarded bits", fwd_n - t0, 8);
    blk_done = 1; tick(); blk_done = 0; tick();
    check(busy == 1, "R9", "busy_o", int'(busy), 1);
    t0 = txreq_n;
    send_byte(8'h99);
    tick(2 * TOUT);
    check(txreq_n == t0, "R9", "transmit flag while busy", txreq_n - t0, 0);
    check(awake == 1, "R7", "no timeout while busy", int'(awake), 1);
    exec_done = 1; tick(); exec_done = 0; tick();
    send_byte(8'h99);
    expect_tx(1, "R9");

    // R10: pause window
    send_byte(8'h66);
    blk_done = 1; blk_pause = 1; tick(); blk_done = 0; blk_pause = 0;
    t0 = fwd_n;
    send_bit(1); send_bit(0); send_bit(1);
    check(fwd_n == t0, "R10", "bits during pause", fwd_n - t0, 0);
    tick(PAUSE);
    check(last_pause == int'(PAUSE), "R10", "pause length", last_pause, int'(PAUSE));
    send_byte(8'h99);
    expect_tx(2, "R10");

    // R4: sleep flag
    t0 = clr_n;
    send_byte(8'hCC); tick(2);
    check(awake == 0, "R4", "asleep after 0xCC", int'(awake), 0);
    check(clr_n - t0 == 1, "R4", "engine clear pulses", clr_n - t0, 1);

    // R6: timeout armed right after wake
    wake = 1; tick(); wake = 0;
    tick(TOUT + 5);
    check(last_run == int'(TOUT), "R6", "awake cycles without tokens", last_run, int'(TOUT));
    // R6: spaced tokens keep it awake, silence ends it
    do_wake();
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1; rx_bit = 1; tick(); rx_valid = 0; tick(TOUT - 10);
    end
    check(awake == 1, "R6", "awake with spaced tokens", int'(awake), 1);
    tick(TOUT);
    check(awake == 0, "R6", "asleep after silence", int'(awake), 0);

    // R8: watchdog, stray wake mid-session
    wake = 1; tick(); wake = 0;
    for (int i = 0; i < int'(WDOG) / 24 + 6; i++) begin
      send_byte(8'h00);
      if (i == 40) begin wake = 1; tick(); wake = 0; end
    end
    check(awake == 0, "R8", "asleep after watchdog", int'(awake), 0);
    check(last_run == int'(WDOG), "R8", "awake cycles", last_run, int'(WDOG));

    tick(4);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule